// File: doc/BRIEF.md
# Three-Phase Voltage Sag Detector

This block monitors the voltage waveform of three line phases in parallel and flags a sag on any phase whose signal stays low for a programmable run of whole half cycles. Each phase supplies signed 16-bit samples with a valid strobe. It also supplies a zero-crossing strobe that closes the current half cycle. For each sample, an 8-bit slice of the sample magnitude is compared against one shared level. A half cycle counts as low only when no sample in it reaches that level. When the run of low half cycles reaches a shared count, the phase's status flag is set.

Flags stay set until software clears them through a per-phase clear strobe. After a phase has been flagged, it cannot raise a new sag until a sample at or above the level shows that the voltage has recovered. A three-bit mask selects which flags drive an active-low, registered interrupt line. Waveform filtering and register-bus decoding sit outside the block.

Top module: `sag_monitor`

## Requirements
- R1: The three phases are tracked independently and at the same time. All three use the same level and the same half-cycle count. Vector bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R2: For each sample, the magnitude |sample| is reduced to its bits 13:6. A magnitude of 16384 or more, including the sample -32768, is treated as 0xFF. A sample is below the level only when level > that 8-bit value, strictly.
- R3: A level of 0x00 or a half-cycle count of 0 disables sag detection, and no flag is ever set.
- R4: With count N, a flag is set in the same clock cycle as the zero-crossing strobe that ends the Nth consecutive low half cycle. The flag is visible after that clock edge.
- R5: A valid sample at or above the level makes its half cycle not low and restarts that phase's run at zero. This includes a sample that arrives in the same cycle as the zero-crossing strobe.
- R6: Flags are sticky and are cleared per phase by the clear strobe. If a set and a clear occur in the same cycle, the set wins.
- R7: A flagged phase cannot raise a new flag until a valid sample at or above the level has been seen on that phase.
- R8: irq_n is the inverse of the OR of (flag AND mask) over the phases. It is registered, so it follows the flags and the mask one clock later.
- R9: After synchronous reset, all flags are 0, irq_n is 1, every run count is 0, and every phase is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 3 | Per-phase sample valid |
| smp_i | input | 3x16 | Per-phase signed sample, index 0 = A |
| zc_i | input | 3 | Per-phase zero-crossing strobe ending a half cycle |
| level_i | input | 8 | Shared sag level |
| hc_limit_i | input | 8 | Shared number of low half cycles to flag |
| mask_i | input | 3 | Per-phase interrupt enable |
| clr_i | input | 3 | Per-phase flag clear strobe |
| sag_flag_o | output | 3 | Sticky per-phase sag flags |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
On every cycle, the assertions check the following:
- A flag rises only on a zero-crossing cycle, and only while the level was nonzero.
- Flags hold until cleared.
- A sample at or above the level zeroes the run count.
- irq_n goes low one cycle after any enabled flag.

Only the bench scenarios can show the rest:
- The exact half cycle on which a flag appears.
- The strict comparison at the 0x40 boundary.
- The saturation of large magnitudes.
- Suppression of a re-flag until recovery.
- The set-over-clear priority.
- The disabling effect of a zero level or a zero count.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int NPH     = 3;
  localparam int SMP_W   = 16;
  localparam int LVL_W   = 8;
  localparam int FLD_LSB = 6;
  localparam int CNT_W   = 8;
endpackage

// File: rtl/sag_phase_tracker.sv
module sag_phase_tracker #(
  parameter int SMP_W   = 16,
  parameter int LVL_W   = 8,
  parameter int FLD_LSB = 6,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             zc_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             clr_i,
  output logic             flag_o
);
  localparam int FLD_MSB = FLD_LSB + LVL_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SMP_W:0]   sext, mag;
  logic             ovf;
  logic [LVL_W-1:0] field;
  logic             below, high_now, enabled, hit;
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             hc_ok_q, armed_q, flag_q;

  // R2: magnitude slice with saturation above the window
  always_comb begin
    sext  = {smp_i[SMP_W-1], smp_i};
    mag   = smp_i[SMP_W-1] ? (~sext + 1'b1) : sext;
    ovf   = |mag[SMP_W:FLD_MSB+1];
    field = ovf ? {LVL_W{1'b1}} : mag[FLD_MSB:FLD_LSB];
    below = level_i > field;
  end

  assign high_now = vld_i && !below;
  assign enabled  = (level_i != '0) && (limit_i != '0);
  assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign hit      = zc_i && hc_ok_q && !high_now && enabled && armed_q &&
                    (cnt_inc >= limit_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      hc_ok_q <= 1'b1;
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      if (zc_i) begin
        hc_ok_q <= 1'b1;
        if (hc_ok_q && !high_now && enabled) cnt_q <= cnt_inc;
        else                                 cnt_q <= '0;
      end else if (high_now) begin
        hc_ok_q <= 1'b0;
        cnt_q   <= '0;
      end
      if (high_now)  armed_q <= 1'b1;
      else if (hit)  armed_q <= 1'b0;
      if (hit)         flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R4
  flag_on_zc_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !$past(flag_q)) |-> $past(zc_i));
  // R3
  level_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !$past(flag_q)) |-> ($past(level_i) != '0));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
  // R5
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !below) |=> (cnt_q == '0));
endmodule

// File: rtl/sag_irq_gen.sv
module sag_irq_gen #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] flag_i,
  input  logic [NPH-1:0] mask_i,
  output logic           irq_n_o
);
  logic irq_n_q;

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~|(flag_i & mask_i);
  end

  assign irq_n_o = irq_n_q;

  // R8
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((flag_i & mask_i) != '0) |=> !irq_n_q);
  // R8
  irq_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((flag_i & mask_i) == '0) |=> irq_n_q);
endmodule

// File: rtl/sag_monitor.sv
module sag_monitor
  import sag_pkg::*;
#(
  parameter int N_PH   = NPH,
  parameter int S_W    = SMP_W,
  parameter int L_W    = LVL_W,
  parameter int F_LSB  = FLD_LSB,
  parameter int C_W    = CNT_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PH-1:0]           smp_vld_i,
  input  logic [N_PH-1:0][S_W-1:0]  smp_i,
  input  logic [N_PH-1:0]           zc_i,
  input  logic [L_W-1:0]            level_i,
  input  logic [C_W-1:0]            hc_limit_i,
  input  logic [N_PH-1:0]           mask_i,
  input  logic [N_PH-1:0]           clr_i,
  output logic [N_PH-1:0]           sag_flag_o,
  output logic                      irq_n_o
);
  logic [N_PH-1:0] flags;

  // R1: one tracker per phase, shared level and limit
  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    sag_phase_tracker #(
      .SMP_W(S_W), .LVL_W(L_W), .FLD_LSB(F_LSB), .CNT_W(C_W)
    ) u_trk (
      .clk(clk), .rst(rst),
      .vld_i(smp_vld_i[p]), .smp_i(smp_i[p]), .zc_i(zc_i[p]),
      .level_i(level_i), .limit_i(hc_limit_i), .clr_i(clr_i[p]),
      .flag_o(flags[p])
    );
  end

  sag_irq_gen #(.NPH(N_PH)) u_irq (
    .clk(clk), .rst(rst), .flag_i(flags), .mask_i(mask_i), .irq_n_o(irq_n_o)
  );

  assign sag_flag_o = flags;

  // R9
  reset_flags_chk: assert property (@(posedge clk)
    $past(rst) |-> (sag_flag_o == '0 && irq_n_o));
endmodule

// File: tb/sag_monitor_tb.sv
`timescale 1ns/1ps
module sag_monitor_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] vld = '0, zc = '0, clr = '0, mask = '0;
  logic [2:0][15:0] smp = '0;
  logic [7:0] level = 8'h40, limit = 8'd3;
  logic [2:0] flag;
  logic irq_n;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sag_monitor u_dut (
    .clk(clk), .rst(rst), .smp_vld_i(vld), .smp_i(smp), .zc_i(zc),
    .level_i(level), .hc_limit_i(limit), .mask_i(mask), .clr_i(clr),
    .sag_flag_o(flag), .irq_n_o(irq_n)
  );

  // {vld, zc, clr, sample A, sample B, sample C, expected flags}; level 0x40, count 3
  localparam logic [59:0] TBL [16] = '{
    {3'b111,3'b000,3'b000,16'h0800,16'h2000,16'hF800,3'b000},
    {3'b000,3'b111,3'b000,16'h0000,16'h0000,16'h0000,3'b000},
    {3'b111,3'b000,3'b000,16'h0FFF,16'h0800,16'hF001,3'b000},
    {3'b000,3'b111,3'b000,16'h0000,16'h0000,16'h0000,3'b000},
    {3'b111,3'b000,3'b000,16'h0800,16'h0800,16'h1000,3'b000},
    {3'b000,3'b111,3'b000,16'h0000,16'h0000,16'h0000,3'b001},
    {3'b000,3'b111,3'b000,16'h0000,16'h0000,16'h0000,3'b011},
    {3'b000,3'b000,3'b001,16'h0000,16'h0000,16'h0000,3'b010},
    {3'b000,3'b111,3'b000,16'h0000,16'h0000,16'h0000,3'b010},
    {3'b000,3'b111,3'b000,16'h0000,16'h0000,16'h0000,3'b110},
    {3'b001,3'b000,3'b000,16'hE000,16'h0000,16'h0000,3'b110},
    {3'b000,3'b000,3'b110,16'h0000,16'h0000,16'h0000,3'b000},
    {3'b000,3'b001,3'b000,16'h0000,16'h0000,16'h0000,3'b000},
    {3'b000,3'b001,3'b000,16'h0000,16'h0000,16'h0000,3'b000},
    {3'b000,3'b001,3'b000,16'h0000,16'h0000,16'h0000,3'b000},
    {3'b000,3'b001,3'b000,16'h0000,16'h0000,16'h0000,3'b001}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] v, input logic [2:0] z, input logic [2:0] c,
                      input logic [15:0] a, input logic [15:0] b, input logic [15:0] cc);
    vld = v; zc = z; clr = c; smp[0] = a; smp[1] = b; smp[2] = cc;
    @(posedge clk);
    @(negedge clk);
    vld = '0; zc = '0; clr = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 flags", {1'b0, flag}, 4'b0000);
    chk("R9 irq_n", {3'b0, irq_n}, 4'b0001);
    rst = 1'b0;

    // R1 R2 R4 R5 R6 R7 table walk
    for (int i = 0; i < 16; i++) begin
      step(TBL[i][59:57], TBL[i][56:54], TBL[i][53:51],
           TBL[i][50:35], TBL[i][34:19], TBL[i][18:3]);
      chk($sformatf("R1/R4/R5/R6/R7 row %0d", i), {1'b0, flag}, {1'b0, TBL[i][2:0]});
    end

    // R8 mask and interrupt (flag A is set)
    mask = 3'b000; @(posedge clk); @(negedge clk);
    chk("R8 masked", {3'b0, irq_n}, 4'b0001);
    mask = 3'b001; @(posedge clk); @(negedge clk);
    chk("R8 enabled", {3'b0, irq_n}, 4'b0000);
    mask = 3'b110; @(posedge clk); @(negedge clk);
    chk("R8 other mask", {3'b0, irq_n}, 4'b0001);
    mask = 3'b000;

    // R3 level zero disables
    do_reset();
    level = 8'h00; limit = 8'd1;
    for (int i = 0; i < 3; i++) step(3'b000, 3'b111, 3'b000, 0, 0, 0);
    chk("R3 level zero", {1'b0, flag}, 4'b0000);
    // R3 count zero disables
    do_reset();
    level = 8'h40; limit = 8'd0;
    for (int i = 0; i < 3; i++) step(3'b000, 3'b111, 3'b000, 0, 0, 0);
    chk("R3 count zero", {1'b0, flag}, 4'b0000);

    // R2 saturation: -32768 and 16384 are never below 0xFF
    do_reset();
    level = 8'hFF; limit = 8'd1;
    step(3'b011, 3'b000, 3'b000, 16'h8000, 16'h4000, 16'h0000);
    step(3'b000, 3'b111, 3'b000, 0, 0, 0);
    chk("R2 saturate", {1'b0, flag}, 4'b0100);

    // R5 high sample arriving with the zero crossing
    do_reset();
    level = 8'h40; limit = 8'd1;
    step(3'b001, 3'b001, 3'b000, 16'h2000, 0, 0);
    chk("R5 same-cycle high", {1'b0, flag}, 4'b0000);

    // R6 set wins over clear
    do_reset();
    step(3'b000, 3'b001, 3'b001, 0, 0, 0);
    chk("R6 set over clear", {1'b0, flag}, 4'b0001);

    // R4 count 2 flags on second crossing exactly
    do_reset();
    limit = 8'd2;
    step(3'b000, 3'b010, 3'b000, 0, 0, 0);
    chk("R4 not yet", {1'b0, flag}, 4'b0000);
    step(3'b000, 3'b010, 3'b000, 0, 0, 0);
    chk("R4 second half", {1'b0, flag}, 4'b0010);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule